// File: doc/BRIEF.md
# Interrupt Moderation Controller

This block sits between the receive and transmit halves of a network interface and the single interrupt line that goes to the host. It gathers interrupt causes, holds them in a pending register, filters them through a mask, and spaces out interrupts with a throttle interval so that the host is not flooded under heavy traffic.

Each direction owns two delay timers. The per-packet timer restarts on every event of its direction and so expires only after the traffic has gone quiet. The absolute timer starts on the first event and runs to the end without being extended, which bounds the latency under steady traffic. On expiry either timer asks for a descriptor writeback in its direction and then records the direction's timer cause. All delays and the throttle interval are programmed in units of 1024 ns, converted to clock cycles by the `UNIT_CYCLES` parameter. Causes from other sources arrive as pulses on `cause_in`. A post flagged with `post_now` may raise the line even while the throttle interval is still running.

Top module: `intr_moderator`

## Requirements
- R1: A per-packet delay timer with a nonzero setting V, last triggered by an event sampled at edge E, pulses its writeback request high for exactly one cycle after edge E + V*UNIT_CYCLES; every further event of its direction before then restarts the count from that event.
- R2: An absolute delay timer with a nonzero setting V starts on the first event and pulses after edge E + V*UNIT_CYCLES counted from that first event; events while it runs do not extend it.
- R3: A delay timer whose setting is zero never arms and never pulses.
- R4: An expiry of either receive timer drives `rx_wb_req` and, one edge later, sets pending bit 1 (receive timer cause); an expiry of either transmit timer drives `tx_wb_req` and one edge later sets pending bit 0 (transmit writeback cause).
- R5: A pending bit, once set by a cause pulse or a timer, stays set until a read; `cause_rd` presents all pending bits on `cause_rdata` in that cycle and clears them at the next edge, except bits posted in the same cycle.
- R6: With throttling idle, `irq` rises at the same edge that records a pending bit whose mask bit is 1, and stays low for causes whose mask bit is 0; `irq` is never high without an unmasked pending bit.
- R7: A mask write takes effect at its edge: it raises `irq` if an already pending bit becomes unmasked, and drops it if no unmasked pending bit remains.
- R8: A read of the pending register drops `irq` at the next edge.
- R9: With a throttle setting T, nonzero, after each rise of `irq` a further rise cannot happen before T*UNIT_CYCLES edges later; an unmasked cause that arrives meanwhile stays pending and raises `irq` at exactly that edge. T = 0 disables throttling.
- R10: A cause pulse with `post_now` high whose unmasked bits are nonzero raises `irq` at once even while the throttle interval is running.
- R11: Register writes select with `reg_sel`: 0 receive per-packet delay, 1 receive absolute delay, 2 transmit per-packet delay, 3 transmit absolute delay, 4 throttle interval, 5 mask (low NC bits of `reg_wdata`); all reset to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_evt | input | 1 | One-cycle pulse per receive descriptor completion; triggers receive timers |
| tx_evt | input | 1 | One-cycle pulse per transmit descriptor completion; triggers transmit timers |
| cause_in | input | NC | Cause pulses from other sources, one bit per cause |
| post_now | input | 1 | Marks the `cause_in` pulse of this cycle as immediate |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select for writes |
| reg_wdata | input | DW | Register write data |
| cause_rd | input | 1 | Read-and-clear strobe for the pending register |
| cause_rdata | output | NC | Current pending causes |
| irq | output | 1 | Interrupt line to the host |
| rx_wb_req | output | 1 | One-cycle receive descriptor writeback request |
| tx_wb_req | output | 1 | One-cycle transmit descriptor writeback request |

## Verification
The assertions assume that `rx_evt`, `tx_evt`, `cause_in` and `cause_rd` are strobes sampled once per edge, that `reg_sel` stays within the six defined selects, and that `DW` is at least `NC`. The bench drives every input half a cycle away from the sampling edge, holds each strobe for exactly one edge, and writes only defined selects. It sweeps every mask value against every cause pattern, sweeps each delay setting in both modes and both directions, and walks the throttle interval edge by edge, with all expected edges derived from V*UNIT_CYCLES arithmetic.

// File: rtl/imc_pkg.sv
// Shared constants for the interrupt moderation controller.
// Assumes the cause vector is at least two bits wide.
package imc_pkg;

    // Fixed cause bit positions, decoded by software handlers
    localparam int CAUSE_TXW = 0;
    localparam int CAUSE_RXT = 1;

    // Register select codes
    typedef enum logic [2:0] {
        SEL_RX_PKT   = 3'd0,
        SEL_RX_ABS   = 3'd1,
        SEL_TX_PKT   = 3'd2,
        SEL_TX_ABS   = 3'd3,
        SEL_THROTTLE = 3'd4,
        SEL_MASK     = 3'd5
    } imc_sel_e;

    // Number of delay timers: per-packet and absolute for each direction
    localparam int NUM_TIMERS = 4;

endpackage

// File: rtl/imc_delay_timer.sv
// Programmable delay timer for one direction.
// In per-packet mode each event reloads the count; in absolute mode only
// an event while idle arms it. A zero setting stops and disables it.
// The expire output is a registered one-cycle pulse.
// Assumes evt is a one-cycle strobe.
module imc_delay_timer #(
    parameter int DW          = 16,
    parameter int UNIT_CYCLES = 128,
    parameter bit ABS_MODE    = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt,
    input  logic [DW-1:0] cfg,
    output logic          expire
);
    localparam int UW = $clog2(UNIT_CYCLES + 1);
    localparam int CW = DW + UW;
    localparam logic [CW-1:0] UNIT_C = CW'(UNIT_CYCLES);

    logic [CW-1:0] cnt;
    logic          running;
    logic          arm;
    logic [CW-1:0] load_val;

    // Decide whether this event (re)loads the count
    always_comb begin
        load_val = CW'(cfg) * UNIT_C;
        arm      = evt && (!ABS_MODE || !running);
    end

    // Count down and emit the expiry pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
            expire  <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (cfg == '0) begin
                running <= 1'b0;
            end else if (arm) begin
                cnt     <= load_val;
                running <= 1'b1;
            end else if (running) begin
                if (cnt == CW'(1)) begin
                    running <= 1'b0;
                    expire  <= 1'b1;
                end else begin
                    cnt <= cnt - CW'(1);
                end
            end
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire); // R1

    AST_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg == '0) |=> !expire); // R3

    generate
        if (ABS_MODE) begin : g_abs_chk
            AST_ABS_NO_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
                (running && evt && cfg != '0 && cnt > CW'(1)) |=> (cnt == $past(cnt) - CW'(1))); // R2
        end
    endgenerate

endmodule

// File: rtl/imc_throttle.sv
// Throttle interval counter. A start pulse with a nonzero interval loads
// interval*UNIT_CYCLES-1, so busy clears exactly interval*UNIT_CYCLES
// edges after the start edge. A zero interval never goes busy.
// Assumes start is asserted only on a rising interrupt line.
module imc_throttle #(
    parameter int DW          = 16,
    parameter int UNIT_CYCLES = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] ival,
    output logic          busy
);
    localparam int UW = $clog2(UNIT_CYCLES + 1);
    localparam int CW = DW + UW;
    localparam logic [CW-1:0] UNIT_C = CW'(UNIT_CYCLES);

    logic [CW-1:0] cnt;

    // Load on start, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start && ival != '0) begin
            cnt <= CW'(ival) * UNIT_C - CW'(1);
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    // Busy while any interval remains
    always_comb busy = (cnt != '0);

    AST_BUSY_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start) |=> (cnt == $past(cnt) - CW'(1))); // R9

endmodule

// File: rtl/intr_moderator.sv
// Interrupt moderation controller top.
// Holds the delay and throttle settings and the mask, runs four delay
// timers, records causes in a sticky pending register and drives the
// interrupt line through mask, throttle and immediate bypass.
// Assumes DW >= NC and NC >= 2; strobes are one cycle wide.
module intr_moderator
    import imc_pkg::*;
#(
    parameter int NC          = 4,
    parameter int DW          = 16,
    parameter int UNIT_CYCLES = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_evt,
    input  logic          tx_evt,
    input  logic [NC-1:0] cause_in,
    input  logic          post_now,
    input  logic          reg_we,
    input  logic [2:0]    reg_sel,
    input  logic [DW-1:0] reg_wdata,
    input  logic          cause_rd,
    output logic [NC-1:0] cause_rdata,
    output logic          irq,
    output logic          rx_wb_req,
    output logic          tx_wb_req
);
    logic [DW-1:0] dly_cfg [NUM_TIMERS];
    logic [DW-1:0] thr_cfg;
    logic [NC-1:0] mask;
    logic [NC-1:0] pend;
    logic [NUM_TIMERS-1:0] t_evt;
    logic [NUM_TIMERS-1:0] t_exp;

    logic [NC-1:0] set_vec;
    logic [NC-1:0] pend_n;
    logic [NC-1:0] mask_n;
    logic          hit_n;
    logic          imm_hit;
    logic          irq_n;
    logic          thr_busy;
    logic          thr_start;

    // Hold the timer settings, throttle interval and mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_TIMERS; i++) dly_cfg[i] <= '0;
            thr_cfg <= '0;
            mask    <= '0;
        end else if (reg_we) begin
            case (reg_sel)
                SEL_RX_PKT:   dly_cfg[0] <= reg_wdata;
                SEL_RX_ABS:   dly_cfg[1] <= reg_wdata;
                SEL_TX_PKT:   dly_cfg[2] <= reg_wdata;
                SEL_TX_ABS:   dly_cfg[3] <= reg_wdata;
                SEL_THROTTLE: thr_cfg    <= reg_wdata;
                SEL_MASK:     mask       <= reg_wdata[NC-1:0];
                default:      ;
            endcase
        end
    end

    // Route each direction's event to its pair of timers
    always_comb t_evt = {tx_evt, tx_evt, rx_evt, rx_evt};

    // Timer i: even index per-packet, odd index absolute
    generate
        for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
            imc_delay_timer #(
                .DW          (DW),
                .UNIT_CYCLES (UNIT_CYCLES),
                .ABS_MODE    ((i % 2) == 1)
            ) u_tmr (
                .clk    (clk),
                .rst_n  (rst_n),
                .evt    (t_evt[i]),
                .cfg    (dly_cfg[i]),
                .expire (t_exp[i])
            );
        end
    endgenerate

    // Writeback requests per direction
    always_comb begin
        rx_wb_req = t_exp[0] | t_exp[1];
        tx_wb_req = t_exp[2] | t_exp[3];
    end

    // Next pending, mask and line state
    always_comb begin
        set_vec            = cause_in;
        set_vec[CAUSE_RXT] = cause_in[CAUSE_RXT] | rx_wb_req;
        set_vec[CAUSE_TXW] = cause_in[CAUSE_TXW] | tx_wb_req;
        pend_n  = (cause_rd ? '0 : pend) | set_vec;
        mask_n  = (reg_we && reg_sel == SEL_MASK) ? reg_wdata[NC-1:0] : mask;
        hit_n   = |(pend_n & mask_n);
        imm_hit = post_now && |(cause_in & mask_n);
        if (cause_rd)                  irq_n = 1'b0;
        else if (!hit_n)               irq_n = 1'b0;
        else if (irq)                  irq_n = 1'b1;
        else if (imm_hit || !thr_busy) irq_n = 1'b1;
        else                           irq_n = 1'b0;
        thr_start = irq_n && !irq;
    end

    // Register pending causes and the interrupt line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
            irq  <= 1'b0;
        end else begin
            pend <= pend_n;
            irq  <= irq_n;
        end
    end

    // Throttle interval between rises
    imc_throttle #(
        .DW          (DW),
        .UNIT_CYCLES (UNIT_CYCLES)
    ) u_thr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (thr_start),
        .ival  (thr_cfg),
        .busy  (thr_busy)
    );

    // Present pending causes for reading
    always_comb cause_rdata = pend;

    AST_WB_SETS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_wb_req |=> pend[CAUSE_RXT]); // R4

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !cause_rd |=> ((pend & $past(pend)) == $past(pend))); // R5

    AST_LINE_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((pend & mask) != '0)); // R6

    AST_READ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        cause_rd |=> !irq); // R8

    AST_THROTTLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && thr_busy && !imm_hit) |=> !irq); // R9

endmodule

// File: tb/intr_moderator_bench.sv
module intr_moderator_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NC   = 4;
    localparam int DW   = 8;
    localparam int UNIT = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_evt = 1'b0;
    logic          tx_evt = 1'b0;
    logic [NC-1:0] cause_in = '0;
    logic          post_now = 1'b0;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_sel = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic          cause_rd = 1'b0;
    logic [NC-1:0] cause_rdata;
    logic          irq;
    logic          rx_wb_req;
    logic          tx_wb_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [NC-1:0] rd_val;

    always #(CLK_PERIOD/2) clk = ~clk;

    intr_moderator #(.NC(NC), .DW(DW), .UNIT_CYCLES(UNIT)) u_intr_moderator (
        .clk(clk), .rst_n(rst_n), .rx_evt(rx_evt), .tx_evt(tx_evt),
        .cause_in(cause_in), .post_now(post_now), .reg_we(reg_we),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .cause_rd(cause_rd),
        .cause_rdata(cause_rdata), .irq(irq), .rx_wb_req(rx_wb_req),
        .tx_wb_req(tx_wb_req));

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic edge_step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] sel, input int val);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = DW'(val);
        edge_step();
        reg_we = 1'b0;
    endtask

    task automatic post(input logic [NC-1:0] c, input logic now);
        cause_in = c; post_now = now;
        edge_step();
        cause_in = '0; post_now = 1'b0;
    endtask

    task automatic rd(output logic [NC-1:0] v);
        cause_rd = 1'b1;
        #1 v = cause_rdata;
        edge_step();
        cause_rd = 1'b0;
    endtask

    // Event at E0 (and E2 if second); expect wb pulse at n=fire_at, irq at fire_at+1
    task automatic run_timer(input string tag, input bit tx, input bit second,
                             input int fire_at, input logic [NC-1:0] cause_bit);
        logic [NC-1:0] v;
        if (tx) tx_evt = 1'b1; else rx_evt = 1'b1;
        for (int n = 0; n <= fire_at + 1; n++) begin
            edge_step();
            if (tx) tx_evt = second && (n == 1); else rx_evt = second && (n == 1);
            if (fire_at > 0) begin
                chk({tag, " wb"}, int'(tx ? tx_wb_req : rx_wb_req), int'(n == fire_at));
                chk({tag, " irq"}, int'(irq), int'(n == fire_at + 1));
            end else begin
                chk({tag, " wb idle"}, int'(tx ? tx_wb_req : rx_wb_req), 0);
                chk({tag, " irq idle"}, int'(irq), 0);
            end
        end
        rd(v);
        chk({tag, " cause"}, int'(v), fire_at > 0 ? int'(cause_bit) : 0);
    endtask

    initial begin
        logic [NC-1:0] v;
        repeat (3) edge_step();
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        chk("R11 reset irq", int'(irq), 0);
        chk("R11 reset rx_wb", int'(rx_wb_req), 0);
        chk("R11 reset tx_wb", int'(tx_wb_req), 0);
        chk("R5 reset pending", int'(cause_rdata), 0);

        // R6 sweep: every mask against every cause pattern
        for (int m = 0; m < 16; m++) begin
            wr(3'd5, m);
            for (int c = 0; c < 16; c++) begin
                post(NC'(c), 1'b0);
                chk("R6 line vs mask", int'(irq), int'((c & m) != 0));
                rd(v);
                chk("R5 read value", int'(v), c);
                chk("R8 read drops", int'(irq), 0);
                chk("R5 cleared", int'(cause_rdata), 0);
            end
        end

        // R7 mask write re-evaluates
        wr(3'd5, 0);
        post(4'b0100, 1'b0);
        chk("R7 masked low", int'(irq), 0);
        wr(3'd5, 4'b0100);
        chk("R7 unmask raises", int'(irq), 1);
        wr(3'd5, 4'b1000);
        chk("R7 remask drops", int'(irq), 0);
        wr(3'd5, 4'b0110);
        chk("R7 unmask again", int'(irq), 1);
        rd(v);
        chk("R5 sticky through mask", int'(v), 4'b0100);
        wr(3'd5, 15);

        // Delay timers, both directions, settings 1..3
        for (int dir = 0; dir < 2; dir++) begin
            for (int val = 1; val <= 3; val++) begin
                logic [2:0] pk;
                logic [2:0] ab;
                logic [NC-1:0] cb;
                pk = dir ? 3'd2 : 3'd0;
                ab = dir ? 3'd3 : 3'd1;
                cb = dir ? 4'b0001 : 4'b0010;
                wr(pk, val); wr(ab, 0);
                run_timer("R1 R4 R11 packet single", bit'(dir), 1'b0, val * UNIT, cb);
                run_timer("R1 packet restart", bit'(dir), 1'b1, val * UNIT + 2, cb);
                wr(pk, 0); wr(ab, val);
                run_timer("R2 R11 absolute", bit'(dir), 1'b1, val * UNIT, cb);
                wr(ab, 0);
                run_timer("R3 zero disabled", bit'(dir), 1'b1, 0, cb);
                repeat (16) begin
                    edge_step();
                    chk("R3 zero stays idle", int'(rx_wb_req | tx_wb_req), 0);
                end
            end
        end

        // R9 throttle: interval 2 units = 8 edges
        wr(3'd4, 2);
        post(4'b0100, 1'b0);                      // n=0 rise
        chk("R9 first rise", int'(irq), 1);
        rd(v);                                    // n=1
        chk("R8 drop", int'(irq), 0);
        post(4'b1000, 1'b0);                      // n=2 held
        chk("R9 held", int'(irq), 0);
        for (int n = 3; n <= 8; n++) begin
            edge_step();
            chk("R9 release edge", int'(irq), int'(n == 8));
        end
        rd(v);                                    // n=9
        chk("R9 held cause kept", int'(v), 4'b1000);
        post(4'b0100, 1'b1);                      // n=10, throttle busy
        chk("R10 immediate bypass", int'(irq), 1);
        rd(v);
        post(4'b0100, 1'b0);
        chk("R10 plain post throttled", int'(irq), 0);
        post(4'b0000, 1'b1);
        chk("R10 empty immediate", int'(irq), 0);
        wr(3'd5, 0);
        post(4'b0010, 1'b1);
        chk("R10 masked immediate", int'(irq), 0);
        rd(v);
        chk("R9 pending after throttle", int'(v), 4'b0110);
        wr(3'd5, 15);
        wr(3'd4, 0);
        repeat (12) edge_step();
        post(4'b0001, 1'b0);
        chk("R9 zero throttle", int'(irq), 1);
        rd(v);
        post(4'b0001, 1'b0);
        chk("R9 zero throttle back-to-back", int'(irq), 1);
        rd(v);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule